// File: doc/BRIEF.md
# Dual Clock Frequency Comparator

The block measures one clock against another. Software picks a reference clock and a clock under test from fixed sets of inputs, loads a seed for each, plus a third seed that sets the width of a tolerance window, and pulses a start control. Each selected clock passes through a fixed predivider and then decrements its own down-counter from its seed. When the reference counter reaches zero, a window counter starts decrementing on the same predivided reference clock. The comparison passes if the test counter reaches zero inside that window, and fails if it gets there before the reference counter or after the window has closed.

Control and status live in the bus clock domain. The run request, the test-expiry event and the verdict cross between domains through two-flop synchronizers. One start runs one comparison. The block then reports done, with error set for a failed check, and returns to idle. Both counters keep their final values, so they can be read out after the comparison.

The select encodings have traps. For the test clock, code 0 picks a dedicated auxiliary input, and the eight general sources sit one code above their index. For both selects, any code above the defined range falls back to the bus clock.

Top module: `freq_cmp`

## Requirements
- R1: After reset, done and error are 0 and both count outputs read 0.
- R2: Reference select codes 0, 1 and 2 route ref_clk_in[0], [1] and [2] to the reference counter. Every other code routes bus_clk.
- R3: Test select code 0 routes aux_clk_in to the test counter.
- R4: Test select code k, for k from 1 to 8, routes gen_clk_in[k-1] to the test counter.
- R5: Test select codes 9 to 15 route bus_clk to the test counter.
- R6: Each selected input is divided by a fixed ratio before it reaches its counter:
  - reference inputs 0 to 2 and reference fallback: 1, 1, 1 and 4;
  - aux_clk_in: 2;
  - gen_clk_in[0..7]: 1, 1, 2, 4, 3, 6, 1, 2;
  - test fallback: 4.
- R7: If the test counter reaches zero after the reference counter does and while the window counter is still nonzero, done rises with error 0. Both count outputs then read 0.
- R8: If the test counter reaches zero while the reference counter is still nonzero, done rises with error 1. The reference count then holds a nonzero value.
- R9: If the window counter reaches zero before the test counter does, done rises with error 1.
- R10: A configuration write (cfg_we) outside the idle state has no effect. Selects and seeds keep the values from the last idle write.
- R11: A start in idle clears done and error and begins a comparison. A start at any other time is ignored.
- R12: While a comparison runs, ref_cnt reads a value below the reference seed and above zero until that counter expires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Control clock; also the fallback clock for unused select codes |
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| ref_clk_in | input | 3 | Dedicated reference clock inputs |
| aux_clk_in | input | 1 | Auxiliary test input, selected by test code 0 |
| gen_clk_in | input | 8 | General test clock sources |
| cfg_we | input | 1 | Load the configuration fields below (honoured only in idle) |
| cfg_ref_sel | input | REF_SEL_W | Reference select code |
| cfg_tst_sel | input | TST_SEL_W | Test select code |
| cfg_ref_seed | input | CNT_W | Reference counter seed |
| cfg_tst_seed | input | CNT_W | Test counter seed |
| cfg_win_seed | input | CNT_W | Tolerance window seed, in predivided reference cycles |
| start | input | 1 | Single-shot start pulse |
| done | output | 1 | Comparison finished (sticky until the next start) |
| error | output | 1 | Comparison failed (valid with done) |
| ref_cnt | output | CNT_W | Live reference count |
| tst_cnt | output | CNT_W | Live test count |

## Verification
The assertions assume three things about the inputs. Configuration is written only while the block is idle, or the write is dropped. start is a single bus-clock pulse. Both selected clocks keep running until a verdict exists.

The bench follows these rules. It drives all inputs on the falling bus edge. It waits for done, and then for the idle drain, before issuing the next start. It picks seeds so that the three expiry instants are several hundred nanoseconds apart, which keeps the synchronizer latency of a few cycles from tipping any verdict.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  localparam int unsigned NUM_REF = 3;
  localparam int unsigned NUM_GEN = 8;
  localparam int unsigned NUM_TST = NUM_GEN + 1;
  localparam int unsigned DIV_W   = 3;
  localparam logic [DIV_W-1:0] BUS_DIV = 3'd4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } fcmp_st_e;

  // Predivider for a reference select code
  function automatic logic [DIV_W-1:0] ref_div(input int unsigned code);
    if (code < NUM_REF) return 3'd1;
    return BUS_DIV;
  endfunction

  // Predivider for a test select code (code 0 = aux, 1..8 = general k-1)
  function automatic logic [DIV_W-1:0] tst_div(input int unsigned code);
    case (code)
      0:       return 3'd2;
      1, 2:    return 3'd1;
      3:       return 3'd2;
      4:       return 3'd4;
      5:       return 3'd3;
      6:       return 3'd6;
      7:       return 3'd1;
      8:       return 3'd2;
      default: return BUS_DIV;
    endcase
  endfunction
endpackage

// File: rtl/fcmp_sync.sv
module fcmp_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/fcmp_clk_sel.sv
module fcmp_clk_sel #(
  parameter int unsigned N  = 3,
  parameter int unsigned SW = 3
) (
  input  logic [N-1:0]  clk_in,
  input  logic          bus_clk,
  input  logic [SW-1:0] sel,
  output logic          clk_out
);
  // Codes beyond the input count fall back to the bus clock
  always_comb begin
    clk_out = bus_clk;
    for (int i = 0; i < N; i++) begin
      if (sel == SW'(i)) clk_out = clk_in[i];
    end
  end
endmodule

// File: rtl/fcmp_pdiv_ctr.sv
module fcmp_pdiv_ctr
  import fcmp_pkg::*;
#(
  parameter int unsigned CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             count_en,
  input  logic [DIV_W-1:0] div,
  input  logic [CNT_W-1:0] seed,
  output logic [CNT_W-1:0] cnt,
  output logic             zero
);
  logic [DIV_W-1:0] pcnt_q;
  logic             step;

  assign step = count_en && (pcnt_q == div - DIV_W'(1));
  assign zero = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      pcnt_q <= '0;
    end else if (load) begin
      cnt    <= seed;
      pcnt_q <= '0;
    end else if (count_en) begin
      pcnt_q <= step ? '0 : pcnt_q + DIV_W'(1);
      if (step && !zero) cnt <= cnt - CNT_W'(1);
    end
  end
endmodule

// File: rtl/fcmp_tst_side.sv
module fcmp_tst_side
  import fcmp_pkg::*;
#(
  parameter int unsigned CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_req,
  input  logic [DIV_W-1:0] div,
  input  logic [CNT_W-1:0] seed,
  output logic [CNT_W-1:0] cnt,
  output logic             expired,
  output logic             armed
);
  logic run_s, run_d, start_p, zero;

  fcmp_sync #(.W(1)) u_run_sync (.clk(clk), .rst_n(rst_n), .d(run_req), .q(run_s));

  assign start_p = run_s && !run_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_d <= 1'b0;
      armed <= 1'b0;
    end else begin
      run_d <= run_s;
      if (start_p)     armed <= 1'b1;
      else if (!run_s) armed <= 1'b0;
    end
  end

  fcmp_pdiv_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(start_p), .count_en(armed && run_s),
    .div(div), .seed(seed), .cnt(cnt), .zero(zero)
  );

  assign expired = armed && zero;
endmodule

// File: rtl/fcmp_ref_side.sv
module fcmp_ref_side
  import fcmp_pkg::*;
#(
  parameter int unsigned CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_req,
  input  logic             tst_exp,
  input  logic [DIV_W-1:0] div,
  input  logic [CNT_W-1:0] ref_seed,
  input  logic [CNT_W-1:0] win_seed,
  output logic [CNT_W-1:0] ref_cnt,
  output logic             pass_o,
  output logic             fail_o,
  output logic             armed
);
  logic run_s, tst_s, run_d, start_p, active;
  logic ref_zero, win_zero;
  logic [CNT_W-1:0] win_cnt;

  fcmp_sync #(.W(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({run_req, tst_exp}), .q({run_s, tst_s})
  );

  assign start_p = run_s && !run_d;
  assign active  = armed && run_s && !pass_o && !fail_o;

  fcmp_pdiv_ctr #(.CNT_W(CNT_W)) u_ref_ctr (
    .clk(clk), .rst_n(rst_n), .load(start_p), .count_en(active),
    .div(div), .seed(ref_seed), .cnt(ref_cnt), .zero(ref_zero)
  );

  // Tolerance window opens when the reference counter has expired
  fcmp_pdiv_ctr #(.CNT_W(CNT_W)) u_win_ctr (
    .clk(clk), .rst_n(rst_n), .load(start_p), .count_en(active && ref_zero),
    .div(div), .seed(win_seed), .cnt(win_cnt), .zero(win_zero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_d  <= 1'b0;
      armed  <= 1'b0;
      pass_o <= 1'b0;
      fail_o <= 1'b0;
    end else begin
      run_d <= run_s;
      if (start_p)     armed <= 1'b1;
      else if (!run_s) armed <= 1'b0;
      if (!run_s) begin
        pass_o <= 1'b0;
        fail_o <= 1'b0;
      end else if (active) begin
        if (tst_s) begin
          if (ref_zero && !win_zero) pass_o <= 1'b1;
          else                       fail_o <= 1'b1;
        end else if (ref_zero && win_zero) begin
          fail_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/freq_cmp.sv
module freq_cmp
  import fcmp_pkg::*;
#(
  parameter int unsigned CNT_W     = 20,
  parameter int unsigned REF_SEL_W = 3,
  parameter int unsigned TST_SEL_W = 4
) (
  input  logic                 bus_clk,
  input  logic                 rst_n,
  input  logic [NUM_REF-1:0]   ref_clk_in,
  input  logic                 aux_clk_in,
  input  logic [NUM_GEN-1:0]   gen_clk_in,
  input  logic                 cfg_we,
  input  logic [REF_SEL_W-1:0] cfg_ref_sel,
  input  logic [TST_SEL_W-1:0] cfg_tst_sel,
  input  logic [CNT_W-1:0]     cfg_ref_seed,
  input  logic [CNT_W-1:0]     cfg_tst_seed,
  input  logic [CNT_W-1:0]     cfg_win_seed,
  input  logic                 start,
  output logic                 done,
  output logic                 error,
  output logic [CNT_W-1:0]     ref_cnt,
  output logic [CNT_W-1:0]     tst_cnt
);
  fcmp_st_e st_q;
  logic [REF_SEL_W-1:0] ref_sel_q;
  logic [TST_SEL_W-1:0] tst_sel_q;
  logic [CNT_W-1:0]     ref_seed_q, tst_seed_q, win_seed_q;
  logic run_q, idle;
  logic ref_clk, tst_clk;
  logic [DIV_W-1:0] ref_dv, tst_dv;
  logic pass_r, fail_r, ref_arm, tst_arm, tst_exp;
  logic pass_s, fail_s, ref_arm_s, tst_arm_s;

  assign idle = (st_q == ST_IDLE);

  // Configuration: accepted only while idle
  always_ff @(posedge bus_clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_sel_q  <= '0;
      tst_sel_q  <= '0;
      ref_seed_q <= '0;
      tst_seed_q <= '0;
      win_seed_q <= '0;
    end else if (cfg_we && idle) begin
      ref_sel_q  <= cfg_ref_sel;
      tst_sel_q  <= cfg_tst_sel;
      ref_seed_q <= cfg_ref_seed;
      tst_seed_q <= cfg_tst_seed;
      win_seed_q <= cfg_win_seed;
    end
  end

  assign ref_dv = ref_div(32'(ref_sel_q));
  assign tst_dv = tst_div(32'(tst_sel_q));

  fcmp_clk_sel #(.N(NUM_REF), .SW(REF_SEL_W)) u_ref_mux (
    .clk_in(ref_clk_in), .bus_clk(bus_clk), .sel(ref_sel_q), .clk_out(ref_clk)
  );

  // Index 0 is the auxiliary input, so general source k sits at code k+1
  fcmp_clk_sel #(.N(NUM_TST), .SW(TST_SEL_W)) u_tst_mux (
    .clk_in({gen_clk_in, aux_clk_in}), .bus_clk(bus_clk), .sel(tst_sel_q), .clk_out(tst_clk)
  );

  fcmp_ref_side #(.CNT_W(CNT_W)) u_ref_side (
    .clk(ref_clk), .rst_n(rst_n), .run_req(run_q), .tst_exp(tst_exp),
    .div(ref_dv), .ref_seed(ref_seed_q), .win_seed(win_seed_q),
    .ref_cnt(ref_cnt), .pass_o(pass_r), .fail_o(fail_r), .armed(ref_arm)
  );

  fcmp_tst_side #(.CNT_W(CNT_W)) u_tst_side (
    .clk(tst_clk), .rst_n(rst_n), .run_req(run_q), .div(tst_dv),
    .seed(tst_seed_q), .cnt(tst_cnt), .expired(tst_exp), .armed(tst_arm)
  );

  fcmp_sync #(.W(4)) u_bus_sync (
    .clk(bus_clk), .rst_n(rst_n),
    .d({pass_r, fail_r, ref_arm, tst_arm}),
    .q({pass_s, fail_s, ref_arm_s, tst_arm_s})
  );

  // Single-shot control
  always_ff @(posedge bus_clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      run_q <= 1'b0;
      done  <= 1'b0;
      error <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (start) begin
          done  <= 1'b0;
          error <= 1'b0;
          run_q <= 1'b1;
          st_q  <= ST_RUN;
        end
        ST_RUN: if (pass_s || fail_s) begin
          done  <= 1'b1;
          error <= fail_s;
          run_q <= 1'b0;
          st_q  <= ST_DRAIN;
        end
        ST_DRAIN: if (!pass_s && !fail_s && !ref_arm_s && !tst_arm_s) begin
          st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fcmp_checker.sv
module fcmp_checker #(
  parameter int unsigned CNT_W     = 20,
  parameter int unsigned REF_SEL_W = 3,
  parameter int unsigned TST_SEL_W = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic                 cfg_we,
  input logic                 idle,
  input logic                 run,
  input logic                 pass_s,
  input logic                 fail_s,
  input logic                 done,
  input logic                 error,
  input logic [REF_SEL_W-1:0] ref_sel,
  input logic [TST_SEL_W-1:0] tst_sel,
  input logic [CNT_W-1:0]     ref_seed,
  input logic [CNT_W-1:0]     tst_seed,
  input logic [CNT_W-1:0]     win_seed
);
  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n) !(pass_s && fail_s)); // R7
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n) error |-> done); // R8
  AST_DONE_FROM_VERDICT: assert property (@(posedge clk) disable iff (!rst_n) $rose(done) |-> $past(pass_s || fail_s)); // R9
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n) (cfg_we && !idle) |=> ($stable(ref_sel) && $stable(tst_sel) && $stable(ref_seed) && $stable(tst_seed) && $stable(win_seed))); // R10
  AST_START_ARMS: assert property (@(posedge clk) disable iff (!rst_n) (start && idle) |=> (run && !done && !error)); // R11
endmodule

bind freq_cmp fcmp_checker #(.CNT_W(CNT_W), .REF_SEL_W(REF_SEL_W), .TST_SEL_W(TST_SEL_W)) u_chk (
  .clk(bus_clk), .rst_n(rst_n), .start(start), .cfg_we(cfg_we), .idle(idle), .run(run_q),
  .pass_s(pass_s), .fail_s(fail_s), .done(done), .error(error),
  .ref_sel(ref_sel_q), .tst_sel(tst_sel_q), .ref_seed(ref_seed_q),
  .tst_seed(tst_seed_q), .win_seed(win_seed_q)
);

// File: tb/test_freq_cmp.sv
`timescale 1ns/1ps
module test_freq_cmp;
  localparam int CW = 20;

  logic bus_clk = 1'b0, rst_n = 1'b0;
  logic [2:0] ref_clk_in = '0;
  logic aux_clk_in = 1'b0;
  logic [7:0] gen_clk_in = '0;
  logic cfg_we = 1'b0, start = 1'b0;
  logic [2:0] cfg_ref_sel = '0;
  logic [3:0] cfg_tst_sel = '0;
  logic [CW-1:0] cfg_ref_seed = '0, cfg_tst_seed = '0, cfg_win_seed = '0;
  logic done, error;
  logic [CW-1:0] ref_cnt, tst_cnt;

  int checks = 0, errors = 0;

  // Periods in ns of the stimulus clocks
  int ref_per [3] = '{40, 50, 80};
  int gen_per [8] = '{20, 24, 28, 16, 36, 12, 44, 32};
  int gen_rat [8] = '{1, 1, 2, 4, 3, 6, 1, 2};

  always #10 bus_clk = ~bus_clk;
  always #20 ref_clk_in[0] = ~ref_clk_in[0];
  always #25 ref_clk_in[1] = ~ref_clk_in[1];
  always #40 ref_clk_in[2] = ~ref_clk_in[2];
  always #15 aux_clk_in = ~aux_clk_in;
  always #10 gen_clk_in[0] = ~gen_clk_in[0];
  always #12 gen_clk_in[1] = ~gen_clk_in[1];
  always #14 gen_clk_in[2] = ~gen_clk_in[2];
  always #8  gen_clk_in[3] = ~gen_clk_in[3];
  always #18 gen_clk_in[4] = ~gen_clk_in[4];
  always #6  gen_clk_in[5] = ~gen_clk_in[5];
  always #22 gen_clk_in[6] = ~gen_clk_in[6];
  always #16 gen_clk_in[7] = ~gen_clk_in[7];

  freq_cmp i_freq_cmp (
    .bus_clk(bus_clk), .rst_n(rst_n), .ref_clk_in(ref_clk_in), .aux_clk_in(aux_clk_in),
    .gen_clk_in(gen_clk_in), .cfg_we(cfg_we), .cfg_ref_sel(cfg_ref_sel),
    .cfg_tst_sel(cfg_tst_sel), .cfg_ref_seed(cfg_ref_seed), .cfg_tst_seed(cfg_tst_seed),
    .cfg_win_seed(cfg_win_seed), .start(start), .done(done), .error(error),
    .ref_cnt(ref_cnt), .tst_cnt(tst_cnt)
  );

  // Effective counting period (ns) after the predivider
  function automatic int eff_ref(input int code);
    return (code <= 2) ? ref_per[code] : 20 * 4;
  endfunction

  function automatic int eff_tst(input int code);
    if (code == 0) return 30 * 2;
    if (code >= 9) return 20 * 4;
    return gen_per[code-1] * gen_rat[code-1];
  endfunction

  function automatic bit predict_err(input int rs, input int ts, input int rseed,
                                     input int tseed, input int wseed);
    int t_ref, t_win, t_tst;
    t_ref = rseed * eff_ref(rs);
    t_win = t_ref + wseed * eff_ref(rs);
    t_tst = tseed * eff_tst(ts);
    return !(t_tst > t_ref && t_tst < t_win);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic write_cfg(input int rs, input int ts, input int rseed,
                           input int tseed, input int wseed);
    @(negedge bus_clk);
    cfg_ref_sel = 3'(rs); cfg_tst_sel = 4'(ts);
    cfg_ref_seed = CW'(rseed); cfg_tst_seed = CW'(tseed); cfg_win_seed = CW'(wseed);
    cfg_we = 1'b1;
    @(negedge bus_clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge bus_clk);
    start = 1'b1;
    @(negedge bus_clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done && n < 3000) begin
      @(negedge bus_clk);
      n++;
    end
    check(done == 1'b1, req, "done", done, 1);
  endtask

  task automatic settle();
    repeat (60) @(negedge bus_clk);
  endtask

  task automatic run_case(input string req, input int rs, input int ts, input int rseed,
                          input int tseed, input int wseed);
    bit exp;
    exp = predict_err(rs, ts, rseed, tseed, wseed);
    write_cfg(rs, ts, rseed, tseed, wseed);
    pulse_start();
    wait_done(req);
    check(error == exp, req, "error", error, exp);
    settle();
  endtask

  task automatic t_reset();
    check(done == 1'b0, "R1", "done", done, 0);
    check(error == 1'b0, "R1", "error", error, 0);
    check(ref_cnt == '0 && tst_cnt == '0, "R1", "counts", ref_cnt + tst_cnt, 0);
  endtask

  task automatic t_pass();
    run_case("R7", 0, 1, 100, 250, 50);
    check(ref_cnt == '0, "R7", "ref_cnt", ref_cnt, 0);
    check(tst_cnt == '0, "R7", "tst_cnt", tst_cnt, 0);
  endtask

  task automatic t_early();
    run_case("R8", 0, 1, 100, 50, 50);
    check(ref_cnt != '0, "R8", "ref_cnt nonzero", ref_cnt, 1);
  endtask

  task automatic t_late();
    run_case("R9", 0, 1, 100, 400, 50);
  endtask

  task automatic t_routing();
    run_case("R3", 0, 0, 100, 80, 50);   // aux /2: 4800 ns
    run_case("R4", 0, 4, 100, 70, 50);   // gen[3] /4: 4480 ns
    run_case("R6", 0, 6, 100, 70, 50);   // gen[5] /6: 5040 ns
    run_case("R6", 0, 6, 100, 30, 50);   // gen[5] /6: 2160 ns, early
    run_case("R5", 0, 9, 100, 60, 50);   // bus /4: 4800 ns
    run_case("R5", 0, 15, 100, 60, 50);
    run_case("R2", 3, 1, 50, 250, 25);   // bus /4 reference
    run_case("R2", 5, 1, 50, 250, 25);
    run_case("R2", 2, 1, 50, 250, 25);
    run_case("R2", 1, 1, 80, 250, 40);
  endtask

  task automatic t_busy_ignored();
    write_cfg(0, 1, 100, 250, 50);
    pulse_start();
    repeat (50) @(negedge bus_clk);
    check(ref_cnt > '0 && ref_cnt < CW'(100), "R12", "live ref_cnt", ref_cnt, 50);
    write_cfg(0, 1, 100, 50, 50);     // would fail early if taken
    pulse_start();                    // ignored: already running
    wait_done("R10");
    check(error == 1'b0, "R10", "error after busy write", error, 0);
    settle();
    pulse_start();
    wait_done("R10");
    check(error == 1'b0, "R10", "rerun keeps old config", error, 0);
    settle();
  endtask

  task automatic t_start_clears();
    run_case("R11", 0, 1, 100, 50, 50);
    pulse_start();
    check(done == 1'b0, "R11", "done cleared", done, 0);
    check(error == 1'b0, "R11", "error cleared", error, 0);
    wait_done("R11");
    check(error == 1'b1, "R11", "error", error, 1);
    settle();
  endtask

  bit finished = 1'b0;

  initial begin
    #(20 * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge bus_clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge bus_clk);
    t_pass();
    t_early();
    t_late();
    t_routing();
    t_busy_ignored();
    t_start_clears();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule